// File: doc/BRIEF.md
# UART Host Data and Status Registers

This block is the processor-facing side of a serial port. A single data address serves two buffers. A write to it fills a one-byte transmit holding slot, and a read from it takes the oldest byte out of a two-entry receive queue. A second address holds the status byte. Software reads the three flags there, and it can clear the transmit-done flag by writing to that address.

The block does not serialise anything. It hands the held byte to an external shift engine through a combinational load strobe, which fires when that engine reports it is idle. It accepts finished characters from an external receive engine through a push strobe. The character size is 5, 6, 7 or 8 bits. Bits above the active size are dropped on the way out and return as zeros on the way in. Each flag, ANDed with its own enable, drives one interrupt request.

Top module: `uart_host_regs`

## Requirements
- R1: A write with `addr`=0 while `dre` is 1 stores the byte in the holding slot, presents it on `tx_data` from the next cycle, and drops `dre` to 0 in that cycle.
- R2: A write with `addr`=0 while `dre` is 0 is ignored, and `tx_data` keeps its previous value.
- R3: `tx_load` is 1 in any cycle where `tx_en`, `tx_empty` and a full holding slot are all present. After that edge the slot is empty and `dre` is 1.
- R4: A read with `addr`=0 returns the oldest queued byte on `rdata` in the same cycle and removes it at the clock edge. Two entries come back in arrival order. A read of an empty queue returns zero and has no effect. A read with `addr`=1 never removes an entry.
- R5: `rxc` is 1 exactly when the receive queue holds at least one unread byte.
- R6: A push while the queue holds two entries, with no read in the same cycle, is dropped and sets the overrun bit, status bit 4. The next read with `addr`=0 clears that bit.
- R7: While `rx_en` is 0, the queue is emptied, the overrun bit is cleared and pushes are ignored.
- R8: `txc` sets when `tx_frame_done` pulses while the holding slot is empty and no byte is being written in that cycle. When a byte is waiting, `txc` stays low.
- R9: `txc` clears on `txc_ack`, or on a write with `addr`=1 whose bit 6 is 1. A set in the same cycle takes priority over the clear.
- R10: After reset `dre` is 1 and `rxc`, `txc` and overrun are 0. The status byte read with `addr`=1 is {`rxc`, `txc`, `dre`, overrun, 0000}, most significant bit first.
- R11: `char_size` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The unused upper bits are zeroed in the held transmit byte and in every received byte.
- R12: `irq_rxc`, `irq_txc` and `irq_dre` each equal their flag ANDed with the matching enable input, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 0 selects the data address, 1 selects status |
| wr_en | input | 1 | Host write strobe |
| wdata | input | DATA_W | Host write data |
| rd_en | input | 1 | Host read strobe; at `addr`=0 it removes a queued byte |
| rdata | output | DATA_W | Host read data (combinational) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; low empties the queue |
| char_size | input | 2 | Character size code (0..3 gives 5..8 bits) |
| ie_rxc | input | 1 | Receive-complete interrupt enable |
| ie_txc | input | 1 | Transmit-complete interrupt enable |
| ie_dre | input | 1 | Data-register-empty interrupt enable |
| tx_empty | input | 1 | Shift engine is idle and can take a byte |
| tx_frame_done | input | 1 | Shift engine finished a whole frame (pulse) |
| tx_load | output | 1 | Transfer strobe to the shift engine |
| tx_data | output | DATA_W | Held transmit byte |
| rx_push | input | 1 | Receive engine delivers a character |
| rx_data | input | DATA_W | Received character |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge |
| rxc | output | 1 | Receive-complete flag |
| txc | output | 1 | Transmit-complete flag |
| dre | output | 1 | Data-register-empty flag |
| irq_rxc | output | 1 | Receive-complete interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Data-register-empty interrupt request |

## Verification
The bench uses the default `DATA_W` of 8, so the four character-size codes cover 5, 6, 7 and 8 bits. Every code is swept against a set of byte patterns whose expected masks are computed arithmetically. A two-entry queue is small enough that the bench walks every fill level from empty to full, overrun included, under each code. That also brings in reads of an empty queue, status reads that must not remove an entry, and the same-cycle priority of the transmit-done set over its clear.

// File: rtl/uart_host_regs.sv
module uart_host_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [1:0]        char_size,
  input  logic              ie_rxc,
  input  logic              ie_txc,
  input  logic              ie_dre,
  input  logic              tx_empty,
  input  logic              tx_frame_done,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              txc_ack,
  output logic              rxc,
  output logic              txc,
  output logic              dre,
  output logic              irq_rxc,
  output logic              irq_txc,
  output logic              irq_dre
);
  localparam int MIN_BITS = DATA_W - 3;
  localparam int DEPTH    = 2;
  localparam int CNT_W    = $clog2(DEPTH + 1);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [DATA_W-1:0] char_mask;
  assign char_mask = ~(ONES << (MIN_BITS + int'(char_size)));

  logic hold_full;
  logic [DATA_W-1:0] hold_q;
  logic wr_data, wr_stat, rd_data, wr_take;

  assign wr_data = wr_en && !addr;
  assign wr_stat = wr_en && addr;
  assign rd_data = rd_en && !addr;
  assign wr_take = wr_data && !hold_full;
  assign dre     = !hold_full;
  assign tx_load = tx_en && hold_full && tx_empty;
  assign tx_data = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
    end else if (wr_take) begin
      hold_full <= 1'b1;
      hold_q    <= wdata & char_mask;
    end else if (tx_load) begin
      hold_full <= 1'b0;
    end
  end

  logic txc_q, txc_set, txc_clr;
  assign txc_set = tx_frame_done && !hold_full && !wr_take;
  assign txc_clr = txc_ack || (wr_stat && wdata[DATA_W-2]);
  assign txc     = txc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       txc_q <= 1'b0;
    else if (txc_set) txc_q <= 1'b1;
    else if (txc_clr) txc_q <= 1'b0;
  end

  logic [DATA_W-1:0] queue_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q, wr_pos;
  logic              ovr_q, pop, push_ok;

  assign pop     = rd_data && (cnt_q != '0);
  assign push_ok = rx_push && rx_en && ((cnt_q < CNT_W'(DEPTH)) || pop);
  assign wr_pos  = cnt_q - CNT_W'(pop);
  assign rxc     = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop);
      if (rx_push && !push_ok) ovr_q <= 1'b1;
      else if (rd_data)        ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (pop) queue_q[0] <= queue_q[1];
    if (push_ok) queue_q[wr_pos[0]] <= rx_data & char_mask;
  end

  logic [DATA_W-1:0] status;
  assign status = {rxc, txc_q, dre, ovr_q, {(DATA_W-4){1'b0}}};
  assign rdata  = addr ? status : (rxc ? queue_q[0] : '0);

  assign irq_rxc = rxc && ie_rxc;
  assign irq_txc = txc_q && ie_txc;
  assign irq_dre = dre && ie_dre;

  a_r3_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> dre);
  a_r2_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !dre) |=> $stable(tx_data));
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rxc);
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_en && cnt_q == CNT_W'(DEPTH) && !rd_data) |=> (ovr_q && cnt_q == CNT_W'(DEPTH)));
  a_r9_txc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txc_q && !txc_ack && !wr_stat) |=> txc_q);
  a_r4_depth: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb;
  logic clk = 0, rst_n = 0;
  logic addr = 0, wr_en = 0, rd_en = 0, tx_en = 0, rx_en = 1;
  logic [7:0] wdata = 0, rdata, tx_data, rx_data = 0;
  logic [1:0] char_size = 3;
  logic ie_rxc = 0, ie_txc = 0, ie_dre = 0, tx_empty = 0, tx_frame_done = 0;
  logic tx_load, rx_push = 0, txc_ack = 0, rxc, txc, dre, irq_rxc, irq_txc, irq_dre;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  uart_host_regs #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .tx_en(tx_en), .rx_en(rx_en),
    .char_size(char_size), .ie_rxc(ie_rxc), .ie_txc(ie_txc), .ie_dre(ie_dre),
    .tx_empty(tx_empty), .tx_frame_done(tx_frame_done), .tx_load(tx_load),
    .tx_data(tx_data), .rx_push(rx_push), .rx_data(rx_data), .txc_ack(txc_ack),
    .rxc(rxc), .txc(txc), .dre(dre), .irq_rxc(irq_rxc), .irq_txc(irq_txc),
    .irq_dre(irq_dre));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    addr = a; rd_en = 1; #1 d = rdata; tick(); rd_en = 0;
  endtask

  task automatic push(input logic [7:0] d);
    rx_data = d; rx_push = 1; tick(); rx_push = 0;
  endtask

  function automatic logic [7:0] mask_of(input int cs);
    return 8'((1 << (5 + cs)) - 1);
  endfunction

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r, prev;
    tick(); tick(); rst_n = 1; tick();
    chk("R10 dre reset", dre, 1);
    chk("R10 rxc reset", rxc, 0);
    chk("R10 txc reset", txc, 0);
    bus_read(1, r);
    chk("R10 status reset", r, 8'h20);
    ie_dre = 1; #1 chk("R12 irq_dre", irq_dre, 1);
    ie_dre = 0; #1 chk("R12 irq_dre off", irq_dre, 0);

    for (int cs = 0; cs < 4; cs++) begin
      char_size = 2'(cs);
      for (int k = 0; k < 8; k++) begin
        logic [7:0] d, d2;
        d  = 8'((k * 73 + cs * 41) ^ 8'hA5);
        d2 = ~d;
        bus_write(0, d);
        chk("R1 dre low", dre, 0);
        chk("R11 tx mask", tx_data, d & mask_of(cs));
        bus_write(0, d2);
        chk("R2 ignored write", tx_data, d & mask_of(cs));
        #1 chk("R3 no load without enable", tx_load, 0);
        tx_en = 1; tx_empty = 1; #1
        chk("R3 load strobe", tx_load, 1);
        tick(); tx_en = 0; tx_empty = 0;
        chk("R3 slot empty", dre, 1);
        #1 chk("R3 load ends", tx_load, 0);
      end
    end
    char_size = 3;

    tx_frame_done = 1; tick(); tx_frame_done = 0;
    chk("R8 txc set", txc, 1);
    ie_txc = 1; #1 chk("R12 irq_txc", irq_txc, 1);
    bus_read(1, r);
    chk("R10 status txc", r, 8'h60);
    bus_write(1, 8'hBF);
    chk("R9 write zero keeps", txc, 1);
    bus_write(1, 8'h40);
    chk("R9 write one clears", txc, 0);
    chk("R12 irq_txc low", irq_txc, 0);
    tx_frame_done = 1; tick(); tx_frame_done = 0;
    txc_ack = 1; tick(); txc_ack = 0;
    chk("R9 ack clears", txc, 0);
    tx_frame_done = 1; txc_ack = 1; tick(); tx_frame_done = 0; txc_ack = 0;
    chk("R9 set wins", txc, 1);
    txc_ack = 1; tick(); txc_ack = 0;
    bus_write(0, 8'h11);
    tx_frame_done = 1; tick(); tx_frame_done = 0;
    chk("R8 held byte blocks txc", txc, 0);
    tx_en = 1; tx_empty = 1; tick(); tx_en = 0; tx_empty = 0;
    ie_txc = 0;

    for (int cs = 0; cs < 4; cs++) begin
      char_size = 2'(cs);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] a, b, c;
        a = 8'(k * 97 + cs * 13 + 8'hF0);
        b = 8'(a * 3 + 8'h5B);
        c = 8'h3C ^ a;
        chk("R5 empty", rxc, 0);
        bus_read(0, r);
        chk("R4 empty read zero", r, 0);
        push(a);
        chk("R5 one entry", rxc, 1);
        ie_rxc = 1; #1 chk("R12 irq_rxc", irq_rxc, 1); ie_rxc = 0;
        push(b);
        push(c);
        bus_read(1, r);
        chk("R6 overrun bit", r, 8'hB0);
        bus_read(1, r);
        chk("R4 status read no pop", r[7], 1);
        bus_read(0, r);
        chk("R11 rx mask first", r, a & mask_of(cs));
        bus_read(1, r);
        chk("R6 overrun cleared", r[4], 0);
        bus_read(0, r);
        chk("R4 second in order", r, b & mask_of(cs));
        chk("R5 drained", rxc, 0);
      end
    end

    char_size = 3;
    push(8'h77); push(8'h78);
    addr = 0; rd_en = 1; rx_data = 8'h79; rx_push = 1; #1 r = rdata;
    tick(); rd_en = 0; rx_push = 0;
    chk("R6 push with pop accepted", r, 8'h77);
    bus_read(1, r);
    chk("R6 no overrun on pop", r[4], 0);
    bus_read(0, r); chk("R4 order after refill", r, 8'h78);
    bus_read(0, r); chk("R4 refilled entry", r, 8'h79);

    push(8'h12); push(8'h34); push(8'h56);
    rx_en = 0; tick();
    chk("R7 flush", rxc, 0);
    push(8'h9A);
    chk("R7 push ignored", rxc, 0);
    rx_en = 1; tick();
    bus_read(1, r);
    chk("R7 overrun cleared by flush", r, 8'h20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule